// File: doc/BRIEF.md
# Dual-Processor Messaging Mailbox

This block is a shared mailbox that connects two processors, called side A and side B, which run on a single common clock. Each side has a small register bus with a word address, write data, read data, a write strobe and a read strobe. Four data lanes run in each direction. A word that one side writes into its transmit slot for lane n appears in the receive slot for lane n on the other side. Each lane keeps one flag that is seen from both ends: "full" at the receiver and "empty" at the sender.

Every lane has its own receive-interrupt enable and its own transmit-interrupt enable. This lets a sender split a message of one to four words across the lanes while the receiver unmasks only the lane that is written last, so the whole message raises a single interrupt. Each side also has four doorbell bits that carry no data. Writing a doorbell bit sets a pending flag on the opposite side, and that flag can raise an interrupt. Each side drives one registered interrupt line.

Each lane in each direction is a two-state machine with states LANE_EMPTY and LANE_FULL. The push transition (a sender write) takes LANE_EMPTY to LANE_FULL. The pop transition (a receiver read) takes LANE_FULL to LANE_EMPTY. A push while in LANE_FULL stays in LANE_FULL, and this covers both an overwrite and a push that arrives together with a pop.

Top module: `mbx_dual`

Word address map, the same on both sides. Addresses 0 to 3 select lane n: a write goes to the lane's transmit slot and a read comes from its receive slot. Address 4 is status. Address 5 is control. Address 6 is the doorbell request. Every other address reads as zero.

## Requirements
- R1: After reset, each side's status reads 0x000000F0 (all its transmit lanes empty, nothing full, no doorbell pending), each control register reads 0, and both interrupt outputs are low.
- R2: A write to address n (0..3) on one side stores the word in lane n toward the other side. From the next cycle, a read of address n on the other side returns that word. The receiver's status bit n (receive full) is then 1 and the sender's status bit 4+n (transmit empty) is 0.
- R3: A read of address n (0..3) on the receiving side clears that side's full bit n and sets the sender's empty bit 4+n from the next cycle.
- R4: A write to a lane that is still full replaces the stored word and leaves the lane full. No older word is kept.
- R5: Control register bits [3:0] enable the receive interrupt of lanes 0..3. The interrupt output rises exactly one cycle after an enabled lane becomes full, and falls one cycle after the condition goes away.
- R6: With only receive lane 3 enabled, writes to lanes 0, 1 and 2 raise no interrupt, and the following write to lane 3 raises it.
- R7: Control bits [7:4] enable the transmit interrupt of lanes 0..3. The interrupt is asserted while an enabled transmit lane is empty: it is lost when the side writes the lane and returns after the other side reads it.
- R8: A write to address 6 with bits [3:0] set sets the matching pending bits [11:8] of the other side's status. A pending bit raises that side's interrupt when control bit 8+n is set. Writing 1 to status bit 8+n clears it.
- R9: Control (address 5) keeps bits [11:0] of the written word and reads them back with the upper bits zero. Addresses 6 and 7 read as zero.
- R10: When the receiver reads lane n in the same cycle as the sender writes it, the read returns the old word and the lane stays full with the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_we | input | 1 | Side A write strobe |
| a_re | input | 1 | Side A read strobe (a read of a lane pops it) |
| a_rdata | output | 32 | Side A read data, combinational from a_addr |
| a_irq | output | 1 | Side A registered interrupt |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_we | input | 1 | Side B write strobe |
| b_re | input | 1 | Side B read strobe (a read of a lane pops it) |
| b_rdata | output | 32 | Side B read data, combinational from b_addr |
| b_irq | output | 1 | Side B registered interrupt |

## Verification
The hardest case to reach from the ports is a collision, where the receiver pops a lane in exactly the same cycle as the sender pushes it again. It needs both buses strobed on the same edge, and its result can only be seen one read later. The bench drives side A's read and side B's write from a single task at the same falling edge. It checks that the old word comes back and that the status still shows the lane full, and then reads again to get the new word. Checking a masked multi-word message also takes care: the interrupt has to be sampled after each masked write and again on both sides of the one-cycle register delay when the last lane lands.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Per-lane occupancy state, one machine per lane and direction
    typedef enum logic {
        LANE_EMPTY = 1'b0,
        LANE_FULL  = 1'b1
    } lane_state_e;

endpackage

// File: rtl/mbx_lane.sv
module mbx_lane
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    lane_state_e state_q;
    lane_state_e state_d;
    logic [DATA_W-1:0] data_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: a push always wins over a pop in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_EMPTY: if (push) state_d = LANE_FULL;
            LANE_FULL: begin
                if (push)     state_d = LANE_FULL;
                else if (pop) state_d = LANE_EMPTY;
            end
            default: state_d = LANE_EMPTY;
        endcase
    end

    // Payload holds the most recent pushed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (push) begin
            data_q <= push_data;
        end
    end

    // Outputs
    always_comb begin
        full = (state_q == LANE_FULL);
        data = data_q;
    end

endmodule

// File: rtl/mbx_port.sv
module mbx_port #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         we,
    input  logic                         re,
    output logic [DATA_W-1:0]            rdata,
    output logic                         irq,
    // outgoing lanes
    output logic [LANES-1:0]             tx_push,
    output logic [DATA_W-1:0]            tx_word,
    input  logic [LANES-1:0]             tx_full,
    // incoming lanes
    output logic [LANES-1:0]             rx_pop,
    input  logic [LANES-1:0]             rx_full,
    input  logic [LANES-1:0][DATA_W-1:0] rx_data,
    // doorbells
    output logic [LANES-1:0]             bell_out,
    input  logic [LANES-1:0]             bell_in
);

    localparam int IDX_W  = $clog2(LANES);
    localparam int CTRL_W = 3 * LANES;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(LANES);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(LANES + 1);
    localparam logic [ADDR_W-1:0] BELL_ADDR = ADDR_W'(LANES + 2);

    logic [CTRL_W-1:0] ctrl_q;
    logic [LANES-1:0]  pend_q;
    logic [LANES-1:0]  pend_clr;
    logic [LANES-1:0]  rx_en;
    logic [LANES-1:0]  tx_en;
    logic [LANES-1:0]  bell_en;
    logic [LANES-1:0]  tx_empty;
    logic              lane_sel;
    logic              irq_q;
    logic              irq_d;

    assign lane_sel = (addr < STAT_ADDR);
    assign tx_empty = ~tx_full;
    assign rx_en    = ctrl_q[LANES-1:0];
    assign tx_en    = ctrl_q[2*LANES-1:LANES];
    assign bell_en  = ctrl_q[3*LANES-1:2*LANES];
    assign tx_word  = wdata;

    // Lane strobes
    for (genvar n = 0; n < LANES; n++) begin : g_strobe
        assign tx_push[n] = we && (addr == ADDR_W'(n));
        assign rx_pop[n]  = re && (addr == ADDR_W'(n));
    end

    assign bell_out = (we && addr == BELL_ADDR) ? wdata[LANES-1:0] : '0;
    assign pend_clr = (we && addr == STAT_ADDR) ? wdata[3*LANES-1:2*LANES] : '0;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we && addr == CTRL_ADDR) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    // Doorbell pending flags: a set from the far side wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | bell_in;
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (lane_sel) begin
            rdata = rx_data[addr[IDX_W-1:0]];
        end else if (addr == STAT_ADDR) begin
            rdata[CTRL_W-1:0] = {pend_q, tx_empty, rx_full};
        end else if (addr == CTRL_ADDR) begin
            rdata[CTRL_W-1:0] = ctrl_q;
        end
    end

    // Registered interrupt
    always_comb begin
        irq_d = |(rx_full & rx_en) | |(tx_empty & tx_en) | |(pend_q & bell_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/mbx_dual.sv
module mbx_dual #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_we,
    input  logic              a_re,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq
);

    logic [LANES-1:0]             a_push;
    logic [LANES-1:0]             b_push;
    logic [LANES-1:0]             a_pop;
    logic [LANES-1:0]             b_pop;
    logic [DATA_W-1:0]            a_word;
    logic [DATA_W-1:0]            b_word;
    logic [LANES-1:0]             a2b_full;
    logic [LANES-1:0]             b2a_full;
    logic [LANES-1:0][DATA_W-1:0] a2b_data;
    logic [LANES-1:0][DATA_W-1:0] b2a_data;
    logic [LANES-1:0]             a_bell;
    logic [LANES-1:0]             b_bell;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        mbx_lane #(.DATA_W(DATA_W)) u_a2b (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (a_push[n]),
            .push_data (a_word),
            .pop       (b_pop[n]),
            .full      (a2b_full[n]),
            .data      (a2b_data[n])
        );
        mbx_lane #(.DATA_W(DATA_W)) u_b2a (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (b_push[n]),
            .push_data (b_word),
            .pop       (a_pop[n]),
            .full      (b2a_full[n]),
            .data      (b2a_data[n])
        );
    end

    mbx_port #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_port_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (a_addr),
        .wdata    (a_wdata),
        .we       (a_we),
        .re       (a_re),
        .rdata    (a_rdata),
        .irq      (a_irq),
        .tx_push  (a_push),
        .tx_word  (a_word),
        .tx_full  (a2b_full),
        .rx_pop   (a_pop),
        .rx_full  (b2a_full),
        .rx_data  (b2a_data),
        .bell_out (a_bell),
        .bell_in  (b_bell)
    );

    mbx_port #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_port_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (b_addr),
        .wdata    (b_wdata),
        .we       (b_we),
        .re       (b_re),
        .rdata    (b_rdata),
        .irq      (b_irq),
        .tx_push  (b_push),
        .tx_word  (b_word),
        .tx_full  (b2a_full),
        .rx_pop   (b_pop),
        .rx_full  (a2b_full),
        .rx_data  (a2b_data),
        .bell_out (b_bell),
        .bell_in  (a_bell)
    );

endmodule

// File: rtl/mbx_dual_chk.sv
module mbx_dual_chk #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int ADDR_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            a_addr,
    input logic [DATA_W-1:0]            a_wdata,
    input logic                         a_we,
    input logic                         a_re,
    input logic [ADDR_W-1:0]            b_addr,
    input logic [DATA_W-1:0]            b_wdata,
    input logic                         b_we,
    input logic                         b_re,
    input logic [LANES-1:0]             a2b_full,
    input logic [LANES-1:0]             b2a_full,
    input logic [LANES-1:0][DATA_W-1:0] a2b_data,
    input logic [LANES-1:0][DATA_W-1:0] b2a_data
);

    localparam int IDX_W = $clog2(LANES);

    logic             a_hit;
    logic             b_hit;
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;
    logic             clash;

    assign a_hit = (a_addr < ADDR_W'(LANES));
    assign b_hit = (b_addr < ADDR_W'(LANES));
    assign a_idx = a_addr[IDX_W-1:0];
    assign b_idx = b_addr[IDX_W-1:0];
    assign clash = b_re && b_hit && a_we && a_hit && (a_idx == b_idx);

    // R2
    a2b_push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && a_hit) |=> (a2b_full[$past(a_idx)] && a2b_data[$past(a_idx)] == $past(a_wdata)));

    // R2
    b2a_push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && b_hit) |=> (b2a_full[$past(b_idx)] && b2a_data[$past(b_idx)] == $past(b_wdata)));

    // R3
    a2b_pop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_re && b_hit && !clash) |=> !a2b_full[$past(b_idx)]);

    // R10
    pop_push_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> a2b_full[$past(b_idx)]);

    // R4
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_re && b_hit) |=> ((a2b_full & $past(a2b_full)) == $past(a2b_full)));

endmodule

bind mbx_dual mbx_dual_chk #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_addr   (a_addr),
    .a_wdata  (a_wdata),
    .a_we     (a_we),
    .a_re     (a_re),
    .b_addr   (b_addr),
    .b_wdata  (b_wdata),
    .b_we     (b_we),
    .b_re     (b_re),
    .a2b_full (a2b_full),
    .b2a_full (b2a_full),
    .a2b_data (a2b_data),
    .b2a_data (b2a_data)
);

// File: tb/test_mbx_dual.sv
`timescale 1ns/1ps
module test_mbx_dual;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic        a_we = 1'b0;
    logic        a_re = 1'b0;
    logic [31:0] a_rdata;
    logic        a_irq;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic        b_we = 1'b0;
    logic        b_re = 1'b0;
    logic [31:0] b_rdata;
    logic        b_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mbx_dual i_mbx_dual (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input bit side_b, input logic [3:0] ad, input logic [31:0] d);
        @(negedge clk);
        if (side_b) begin b_we = 1'b1; b_addr = ad; b_wdata = d; end
        else        begin a_we = 1'b1; a_addr = ad; a_wdata = d; end
        @(negedge clk);
        a_we = 1'b0;
        b_we = 1'b0;
    endtask

    task automatic rd(input bit side_b, input logic [3:0] ad, output logic [31:0] d);
        @(negedge clk);
        if (side_b) begin b_re = 1'b1; b_addr = ad; end
        else        begin a_re = 1'b1; a_addr = ad; end
        #1;
        d = side_b ? b_rdata : a_rdata;
        @(negedge clk);
        a_re = 1'b0;
        b_re = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 4'd4, v); check("R1 A status", v, 32'h0F0);
        rd(1, 4'd4, v); check("R1 B status", v, 32'h0F0);
        rd(0, 4'd5, v); check("R1 A control", v, 32'h0);
        rd(1, 4'd5, v); check("R1 B control", v, 32'h0);
        check("R1 irqs", {30'd0, a_irq, b_irq}, 32'h0);
    endtask

    task automatic t_transfer();
        logic [31:0] v;
        wr(0, 4'd2, 32'hCAFE0002);
        rd(1, 4'd4, v); check("R2 B status full bit2", v, 32'h0F4);
        rd(0, 4'd4, v); check("R2 A status empty bit6 low", v, 32'h0B0);
        rd(1, 4'd2, v); check("R2 B lane2 data", v, 32'hCAFE0002);
        rd(1, 4'd4, v); check("R3 B status after pop", v, 32'h0F0);
        rd(0, 4'd4, v); check("R3 A empty restored", v, 32'h0F0);
    endtask

    task automatic t_overwrite();
        logic [31:0] v;
        wr(0, 4'd1, 32'h11111111);
        wr(0, 4'd1, 32'h22222222);
        rd(1, 4'd4, v); check("R4 still full", v, 32'h0F2);
        rd(1, 4'd1, v); check("R4 newest word", v, 32'h22222222);
        rd(1, 4'd4, v); check("R4 single pop empties", v, 32'h0F0);
    endtask

    task automatic t_message();
        logic [31:0] v;
        wr(1, 4'd5, 32'h8);
        for (int n = 0; n < 3; n++) begin
            wr(0, 4'(n), 32'hA0 + n);
            @(negedge clk);
            check("R6 masked lane no irq", {31'd0, b_irq}, 32'h0);
        end
        wr(0, 4'd3, 32'hA3);
        check("R5 irq not before register delay", {31'd0, b_irq}, 32'h0);
        @(negedge clk);
        check("R6 last lane raises irq", {31'd0, b_irq}, 32'h1);
        for (int n = 0; n < 4; n++) begin
            rd(1, 4'(n), v);
            check("R6 message word", v, 32'hA0 + n);
        end
        @(negedge clk);
        check("R5 irq drops after pop", {31'd0, b_irq}, 32'h0);
        wr(1, 4'd5, 32'h0);
    endtask

    task automatic t_tx_irq();
        logic [31:0] v;
        wr(0, 4'd5, 32'h10);
        @(negedge clk);
        check("R7 empty enabled lane irq", {31'd0, a_irq}, 32'h1);
        wr(0, 4'd0, 32'h5A5A);
        @(negedge clk);
        check("R7 irq gone after write", {31'd0, a_irq}, 32'h0);
        rd(1, 4'd0, v);
        @(negedge clk);
        check("R7 irq back after far read", {31'd0, a_irq}, 32'h1);
        wr(0, 4'd5, 32'h0);
        @(negedge clk);
        check("R7 irq off when disabled", {31'd0, a_irq}, 32'h0);
    endtask

    task automatic t_doorbell();
        logic [31:0] v;
        wr(1, 4'd5, 32'h200);
        wr(0, 4'd6, 32'h6);
        rd(1, 4'd4, v); check("R8 B pending bits", v, 32'h6F0);
        rd(0, 4'd4, v); check("R8 A untouched", v, 32'h0F0);
        check("R8 enabled bell irq", {31'd0, b_irq}, 32'h1);
        wr(1, 4'd4, 32'h200);
        rd(1, 4'd4, v); check("R8 clear bit9", v, 32'h4F0);
        check("R8 irq gone with masked bell left", {31'd0, b_irq}, 32'h0);
        wr(1, 4'd4, 32'h400);
        rd(1, 4'd4, v); check("R8 clear bit10", v, 32'h0F0);
        wr(1, 4'd5, 32'h0);
    endtask

    task automatic t_clash();
        logic [31:0] v;
        wr(1, 4'd3, 32'h33);
        @(negedge clk);
        a_re = 1'b1; a_addr = 4'd3;
        b_we = 1'b1; b_addr = 4'd3; b_wdata = 32'h44;
        #1 v = a_rdata;
        check("R10 read returns old word", v, 32'h33);
        @(negedge clk);
        a_re = 1'b0; b_we = 1'b0;
        rd(0, 4'd4, v); check("R10 lane still full", v, 32'h0F8);
        rd(0, 4'd3, v); check("R10 new word", v, 32'h44);
        rd(0, 4'd4, v); check("R10 empty after", v, 32'h0F0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(0, 4'd5, 32'hFFFFFABC);
        rd(0, 4'd5, v); check("R9 control readback", v, 32'h00000ABC);
        wr(0, 4'd5, 32'h0);
        rd(0, 4'd6, v); check("R9 bell reads zero", v, 32'h0);
        rd(0, 4'd7, v); check("R9 unused reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_transfer();
        t_overwrite();
        t_message();
        t_tx_irq();
        t_doorbell();
        t_clash();
        t_ctrl();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule